// File: doc/BRIEF.md
# Skewed Banked Warp Register File with Read Arbiter

This block holds the registers of a set of warps in several banks. Each bank has one read port and one write port, and each bank row carries one named register for every lane of one warp: 32 lanes of 32 bits, which gives a 1024-bit row. A warp and register pair maps to a bank through a per-warp rotation, so the same register of neighbouring warps sits in neighbouring banks and the banks can serve those reads in parallel.

Operand collectors send read requests, each tagged with an operand slot number. Every collector has a small in-order queue inside the block. Each cycle, every bank picks at most one queue head that targets it and reads the row. The data comes out on that bank's response lane one cycle later, tagged with the collector number and the slot. A single writeback port writes one full row per cycle. A write owns its bank for that cycle, so reads of that bank wait.

Each collector queue is a three-state machine. The states are QS_EMPTY, QS_HOLD (occupied but not full) and QS_FULL. A push moves QS_EMPTY to QS_HOLD. A push into the last free entry, with no pop, moves QS_HOLD to QS_FULL. A pop of the last entry, with no push, moves QS_HOLD back to QS_EMPTY. A pop with no push moves QS_FULL to QS_HOLD. With a depth of one, QS_EMPTY and QS_FULL swap directly. `rd_req_ready` is high in every state except QS_FULL.

Top module: `skew_bank_rf`

## Requirements
- R1: The pair (warp w, register r) lives in bank (r + w) mod NUM_BANKS, and its read response appears on response lane number (r + w) mod NUM_BANKS.
- R2: A read returns the whole 1024-bit row (lane k in bits 32k+31 down to 32k), which equals the last value written to that warp and register.
- R3: A bank serves at most one read per cycle. Requests that target the same bank are served in consecutive cycles, one per cycle, and requests to different banks are served in the same cycle.
- R4: In a cycle where `wr_valid` targets bank b, no read is granted from bank b. A waiting read to bank b is granted in the first cycle with no write to b.
- R5: Among collectors waiting on one bank, the grant goes to the first requester at or after that bank's pointer, in increasing collector order with wrap-around. After a grant to collector c, the pointer moves to c + 1. Every pointer starts at 0.
- R6: Each collector queue holds QUEUE_DEPTH requests. `rd_req_ready` for that collector is low while the queue is full, and a request offered while the ready is low is not taken. A collector's responses arrive in the order its requests were accepted.
- R7: A request accepted at clock edge n, with its bank free and no older request queued, is granted during the next cycle and appears on `rsp_*` after edge n+2. The response carries the request's collector number and slot.
- R8: A write presented before edge n is returned by any read granted after edge n.
- R9: After reset, every `rsp_valid` is low and every `rd_req_ready` is high.
- R10: Every accepted request produces exactly one response, and no response appears without an accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_req_valid | input | NUM_COLL | Read request valid, one bit per collector |
| rd_req_warp | input | NUM_COLL x WW | Warp number of each request |
| rd_req_reg | input | NUM_COLL x RW | Register number of each request |
| rd_req_slot | input | NUM_COLL x SW | Operand slot tag of each request |
| rd_req_ready | output | NUM_COLL | Collector queue has room |
| wr_valid | input | 1 | Writeback valid |
| wr_warp | input | WW | Writeback warp number |
| wr_reg | input | RW | Writeback register number |
| wr_data | input | LANES*LANE_W | Writeback row, all lanes |
| rsp_valid | output | NUM_BANKS | Read data valid, one bit per bank |
| rsp_coll | output | NUM_BANKS x CW | Collector tag of each response |
| rsp_slot | output | NUM_BANKS x SW | Slot tag of each response |
| rsp_data | output | NUM_BANKS x LANES*LANE_W | Row read from each bank |

## Verification
The assertions assume that the parameters are powers of two, that NUM_REGS is at least NUM_BANKS, and that every warp and register number on the ports is in range. Under those conditions the bank rotation and the row index stay inside each bank. They also assume that a write arrives at most once per cycle through the single writeback port, which the port structure itself enforces. The random stimulus draws warp, register and slot values only from their legal ranges. It offers requests whether or not a queue has room, so it exercises the back-pressure path, and it mixes in writes that often hit the same banks as pending reads. Directed cases cover the pointer rotation, a write that blocks a read for several cycles, a full queue, and a read right after a write.

// File: rtl/skew_rf_pkg.sv
package skew_rf_pkg;

    // Occupancy states of a collector request queue
    typedef enum logic [1:0] {
        QS_EMPTY = 2'd0,
        QS_HOLD  = 2'd1,
        QS_FULL  = 2'd2
    } qstate_e;

endpackage

// File: rtl/rf_req_queue.sv
module rf_req_queue
    import skew_rf_pkg::*;
#(
    parameter int DEPTH = 2,
    parameter int EW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [EW-1:0] push_data,
    input  logic          pop,
    output logic          ready,
    output logic          head_valid,
    output logic [EW-1:0] head_data
);

    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    logic [EW-1:0]   slots [DEPTH];
    logic [PW-1:0]   rd_ptr, wr_ptr;
    logic [CNTW-1:0] count;
    qstate_e         state, state_nx;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            QS_EMPTY: if (push) state_nx = (DEPTH == 1) ? QS_FULL : QS_HOLD;
            QS_HOLD: begin
                if (push && !pop && count == CNTW'(DEPTH - 1))
                    state_nx = QS_FULL;
                else if (pop && !push && count == CNTW'(1))
                    state_nx = QS_EMPTY;
            end
            QS_FULL:  if (pop && !push) state_nx = (DEPTH == 1) ? QS_EMPTY : QS_HOLD;
            default:  state_nx = QS_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= QS_EMPTY;
        else        state <= state_nx;
    end

    // outputs
    always_comb begin
        ready      = (state != QS_FULL);
        head_valid = (state != QS_EMPTY);
        head_data  = slots[rd_ptr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            count <= count + CNTW'(push) - CNTW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= push_data;
    end

    p_state_tracks_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == QS_EMPTY) == (count == '0)) && ((state == QS_FULL) == (count == CNTW'(DEPTH))));

    p_pop_needs_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> head_valid);

endmodule

// File: rtl/rf_rr_arb.sv
module rf_rr_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);

    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] ptr, win;
    logic [IW:0]   cand;
    logic          found;

    always_comb begin
        grant = '0;
        win   = ptr;
        found = 1'b0;
        cand  = '0;
        for (int i = 0; i < N; i++) begin
            cand = (IW+1)'(ptr) + (IW+1)'(i);
            if (cand >= (IW+1)'(N)) cand = cand - (IW+1)'(N);
            if (!found && req[cand[IW-1:0]]) begin
                found = 1'b1;
                win   = cand[IW-1:0];
            end
        end
        if (found) grant[win] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ptr <= '0;
        else if (found) ptr <= (win == IW'(N - 1)) ? '0 : win + 1'b1;
    end

    p_single_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    p_grant_backed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);

    p_pointer_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req[ptr] |-> grant[ptr]);

endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
    parameter int AW    = 3,
    parameter int ROW_W = 1024,
    parameter int CW    = 2,
    parameter int SW    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_row,
    input  logic [ROW_W-1:0] wr_data,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_row,
    input  logic [CW-1:0]    rd_coll,
    input  logic [SW-1:0]    rd_slot,
    output logic             rsp_valid,
    output logic [CW-1:0]    rsp_coll,
    output logic [SW-1:0]    rsp_slot,
    output logic [ROW_W-1:0] rsp_data
);

    localparam int DEPTH = 1 << AW;

    logic [ROW_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_row] <= wr_data;
        if (rd_en) rsp_data <= mem[rd_row];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_coll  <= '0;
            rsp_slot  <= '0;
        end else begin
            rsp_valid <= rd_en;
            if (rd_en) begin
                rsp_coll <= rd_coll;
                rsp_slot <= rd_slot;
            end
        end
    end

    p_rsp_next_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rsp_valid == $past(rd_en)));

endmodule

// File: rtl/skew_bank_rf.sv
module skew_bank_rf #(
    parameter int NUM_BANKS   = 16,
    parameter int LANES       = 32,
    parameter int LANE_W      = 32,
    parameter int NUM_WARPS   = 4,
    parameter int NUM_REGS    = 32,
    parameter int NUM_COLL    = 4,
    parameter int NUM_SLOTS   = 4,
    parameter int QUEUE_DEPTH = 2,
    localparam int ROW_W = LANES * LANE_W,
    localparam int WW    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
    localparam int RW    = $clog2(NUM_REGS),
    localparam int BW    = $clog2(NUM_BANKS),
    localparam int CW    = (NUM_COLL > 1) ? $clog2(NUM_COLL) : 1,
    localparam int SW    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_COLL-1:0]                 rd_req_valid,
    input  logic [NUM_COLL-1:0][WW-1:0]         rd_req_warp,
    input  logic [NUM_COLL-1:0][RW-1:0]         rd_req_reg,
    input  logic [NUM_COLL-1:0][SW-1:0]         rd_req_slot,
    output logic [NUM_COLL-1:0]                 rd_req_ready,
    input  logic                                wr_valid,
    input  logic [WW-1:0]                       wr_warp,
    input  logic [RW-1:0]                       wr_reg,
    input  logic [ROW_W-1:0]                    wr_data,
    output logic [NUM_BANKS-1:0]                rsp_valid,
    output logic [NUM_BANKS-1:0][CW-1:0]        rsp_coll,
    output logic [NUM_BANKS-1:0][SW-1:0]        rsp_slot,
    output logic [NUM_BANKS-1:0][ROW_W-1:0]     rsp_data
);

    localparam int ROW_AW = WW + RW - BW;
    localparam int EW     = WW + RW + SW;

    logic [NUM_COLL-1:0]              hd_valid;
    logic [NUM_COLL-1:0][WW-1:0]      hd_warp;
    logic [NUM_COLL-1:0][RW-1:0]      hd_reg;
    logic [NUM_COLL-1:0][SW-1:0]      hd_slot;
    logic [NUM_COLL-1:0][BW-1:0]      hd_bank;
    logic [NUM_COLL-1:0][ROW_AW-1:0]  hd_row;
    logic [NUM_COLL-1:0]              pop;
    logic [NUM_BANKS-1:0][NUM_COLL-1:0] gnt_mat;
    logic [NUM_BANKS-1:0]             bank_rd_en;
    logic [RW:0]                      wr_sum;
    logic [BW-1:0]                    wr_bank;
    logic [ROW_AW-1:0]                wr_row;

    // writeback address: rotated bank, row inside the bank
    assign wr_sum  = {1'b0, wr_reg} + (RW+1)'(wr_warp);
    assign wr_bank = wr_sum[BW-1:0];

    // per-collector request queues and head decode
    for (genvar c = 0; c < NUM_COLL; c++) begin : g_coll
        logic [EW-1:0] pdata, hdata;
        logic [RW:0]   hsum;

        assign pdata = {rd_req_warp[c], rd_req_reg[c], rd_req_slot[c]};

        rf_req_queue #(.DEPTH(QUEUE_DEPTH), .EW(EW)) u_queue (
            .clk        (clk),
            .rst_n      (rst_n),
            .push       (rd_req_valid[c] & rd_req_ready[c]),
            .push_data  (pdata),
            .pop        (pop[c]),
            .ready      (rd_req_ready[c]),
            .head_valid (hd_valid[c]),
            .head_data  (hdata)
        );

        assign hd_warp[c] = hdata[EW-1 -: WW];
        assign hd_reg[c]  = hdata[SW +: RW];
        assign hd_slot[c] = hdata[SW-1:0];
        assign hsum       = {1'b0, hd_reg[c]} + (RW+1)'(hd_warp[c]);
        assign hd_bank[c] = hsum[BW-1:0];

        if (RW > BW) begin : g_row_split
            assign hd_row[c] = {hd_warp[c], hd_reg[c][RW-1:BW]};
        end else begin : g_row_warp
            assign hd_row[c] = hd_warp[c];
        end
    end

    if (RW > BW) begin : g_wr_split
        assign wr_row = {wr_warp, wr_reg[RW-1:BW]};
    end else begin : g_wr_warp
        assign wr_row = wr_warp;
    end

    // per-bank arbitration and storage
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [NUM_COLL-1:0] req, gnt;
        logic                wr_here;
        logic [CW-1:0]       sel;

        assign wr_here = wr_valid && (wr_bank == BW'(b));

        always_comb begin
            for (int c = 0; c < NUM_COLL; c++)
                req[c] = hd_valid[c] && (hd_bank[c] == BW'(b)) && !wr_here;
        end

        rf_rr_arb #(.N(NUM_COLL)) u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (req),
            .grant (gnt)
        );

        always_comb begin
            sel = '0;
            for (int c = 0; c < NUM_COLL; c++)
                if (gnt[c]) sel = CW'(c);
        end

        assign gnt_mat[b]    = gnt;
        assign bank_rd_en[b] = |gnt;

        rf_bank #(.AW(ROW_AW), .ROW_W(ROW_W), .CW(CW), .SW(SW)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_here),
            .wr_row    (wr_row),
            .wr_data   (wr_data),
            .rd_en     (bank_rd_en[b]),
            .rd_row    (hd_row[sel]),
            .rd_coll   (sel),
            .rd_slot   (hd_slot[sel]),
            .rsp_valid (rsp_valid[b]),
            .rsp_coll  (rsp_coll[b]),
            .rsp_slot  (rsp_slot[b]),
            .rsp_data  (rsp_data[b])
        );
    end

    // a granted head leaves its queue
    always_comb begin
        pop = '0;
        for (int b = 0; b < NUM_BANKS; b++) pop = pop | gnt_mat[b];
    end

    p_write_owns_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !bank_rd_en[wr_bank]);

    p_grant_only_head_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop & ~hd_valid) == '0);

endmodule

// File: tb/skew_bank_rf_bench.sv
module skew_bank_rf_bench;

    localparam int NB = 16, NC = 4, NW = 4, NR = 32, NS = 4, QD = 2;
    localparam int ROW_W = 1024, WW = 2, RW = 5, CW = 2, SW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NC-1:0]              rd_req_valid = '0;
    logic [NC-1:0][WW-1:0]      rd_req_warp = '0;
    logic [NC-1:0][RW-1:0]      rd_req_reg = '0;
    logic [NC-1:0][SW-1:0]      rd_req_slot = '0;
    logic [NC-1:0]              rd_req_ready;
    logic                       wr_valid = 1'b0;
    logic [WW-1:0]              wr_warp = '0;
    logic [RW-1:0]              wr_reg = '0;
    logic [ROW_W-1:0]           wr_data = '0;
    logic [NB-1:0]              rsp_valid;
    logic [NB-1:0][CW-1:0]      rsp_coll;
    logic [NB-1:0][SW-1:0]      rsp_slot;
    logic [NB-1:0][ROW_W-1:0]   rsp_data;

    always #5 clk = ~clk;

    skew_bank_rf #(.NUM_BANKS(NB), .NUM_WARPS(NW), .NUM_REGS(NR), .NUM_COLL(NC),
                   .NUM_SLOTS(NS), .QUEUE_DEPTH(QD)) u_skew_bank_rf (
        .clk(clk), .rst_n(rst_n),
        .rd_req_valid(rd_req_valid), .rd_req_warp(rd_req_warp), .rd_req_reg(rd_req_reg),
        .rd_req_slot(rd_req_slot), .rd_req_ready(rd_req_ready),
        .wr_valid(wr_valid), .wr_warp(wr_warp), .wr_reg(wr_reg), .wr_data(wr_data),
        .rsp_valid(rsp_valid), .rsp_coll(rsp_coll), .rsp_slot(rsp_slot), .rsp_data(rsp_data)
    );

    int nchk = 0, nfail = 0, cyc = 0;
    bit done = 1'b0;
    logic [ROW_W-1:0] mdl [NW*NR];
    int ew [NC][16], er [NC][16], es [NC][16], ec [NC][16];
    int hd [NC], tl [NC], last_lat [NC], got [NC];
    logic [ROW_W-1:0] last_data [NC];
    int watch = -1, log_n = 0;
    int order_log [16];

    task automatic chk(input bit ok, input string req, input string what);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: %s", req, what);
        end
    endtask

    function automatic logic [ROW_W-1:0] rnd_row();
        logic [ROW_W-1:0] v;
        for (int i = 0; i < ROW_W/32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    // response monitor: samples mid-cycle, after the rising edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            for (int b = 0; b < NB; b++) begin
                if (rsp_valid[b]) begin
                    int c, k, exp_bank;
                    c = int'(rsp_coll[b]);
                    if (tl[c] == hd[c]) begin
                        chk(1'b0, "R10", $sformatf("bank %0d response for collector %0d, outstanding got 0 exp >0", b, c));
                    end else begin
                        k = hd[c] % 16;
                        hd[c]++;
                        exp_bank = (ew[c][k] + er[c][k]) % NB;
                        chk(b == exp_bank, "R1", $sformatf("lane got %0d exp %0d", b, exp_bank));
                        chk(int'(rsp_slot[b]) == es[c][k], "R7",
                            $sformatf("slot got %0d exp %0d", rsp_slot[b], es[c][k]));
                        chk(rsp_data[b] == mdl[ew[c][k]*NR + er[c][k]], "R2",
                            $sformatf("data got %h exp %h", rsp_data[b], mdl[ew[c][k]*NR + er[c][k]]));
                        chk(cyc - ec[c][k] >= 2, "R7",
                            $sformatf("latency got %0d exp >=2", cyc - ec[c][k]));
                        last_lat[c]  = cyc - ec[c][k];
                        last_data[c] = rsp_data[b];
                        got[c]++;
                        if (b == watch) begin
                            order_log[log_n % 16] = c;
                            log_n++;
                        end
                    end
                end
            end
        end
    end

    // records accepted requests and writes, then moves to the next drive point
    task automatic step();
        for (int c = 0; c < NC; c++) begin
            if (rd_req_valid[c] && rd_req_ready[c]) begin
                int k;
                k = tl[c] % 16;
                ew[c][k] = int'(rd_req_warp[c]);
                er[c][k] = int'(rd_req_reg[c]);
                es[c][k] = int'(rd_req_slot[c]);
                ec[c][k] = cyc;
                tl[c]++;
            end
        end
        if (wr_valid) mdl[int'(wr_warp)*NR + int'(wr_reg)] = wr_data;
        @(negedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        rd_req_valid = '0;
        wr_valid = 1'b0;
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic set_req(input int c, input int w, input int r, input int s);
        rd_req_valid[c] = 1'b1;
        rd_req_warp[c]  = WW'(w);
        rd_req_reg[c]   = RW'(r);
        rd_req_slot[c]  = SW'(s);
    endtask

    task automatic set_wr(input int w, input int r, input logic [ROW_W-1:0] d);
        wr_valid = 1'b1;
        wr_warp  = WW'(w);
        wr_reg   = RW'(r);
        wr_data  = d;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: cycles got 150000 exp fewer");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [ROW_W-1:0] val;
        int g0, exp_ord [4];
        void'($urandom(32'd20240611));
        for (int c = 0; c < NC; c++) begin
            hd[c] = 0; tl[c] = 0; got[c] = 0; last_lat[c] = 0;
        end
        repeat (3) @(negedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R9: reset state
        chk(rsp_valid == '0, "R9", $sformatf("rsp_valid got %h exp 0", rsp_valid));
        chk(rd_req_ready == '1, "R9", $sformatf("rd_req_ready got %b exp 1111", rd_req_ready));

        // fill every register
        for (int w = 0; w < NW; w++)
            for (int r = 0; r < NR; r++) begin
                set_wr(w, r, rnd_row());
                step();
            end
        idle(4);

        // R7: single uncontended request, latency and tags
        set_req(2, 1, 5, 3);
        step();
        idle(4);
        chk(got[2] == 1, "R7", $sformatf("responses got %0d exp 1", got[2]));
        chk(last_lat[2] == 2, "R7", $sformatf("latency got %0d exp 2", last_lat[2]));

        // R1/R3: register 7 of four warps falls in four banks, served together
        for (int c = 0; c < NC; c++) set_req(c, c, 7, c);
        step();
        idle(4);
        for (int c = 0; c < NC; c++)
            chk(last_lat[c] == 2, "R1", $sformatf("collector %0d latency got %0d exp 2", c, last_lat[c]));

        // R5: move bank 9 pointer to 2, then all four contend for bank 9
        watch = 9;
        set_req(1, 0, 9, 0);
        step();
        idle(4);
        log_n = 0;
        for (int c = 0; c < NC; c++) set_req(c, c, 9 - c, c);
        step();
        idle(8);
        exp_ord = '{2, 3, 0, 1};
        chk(log_n == 4, "R3", $sformatf("bank 9 responses got %0d exp 4", log_n));
        for (int i = 0; i < 4; i++)
            chk(order_log[i] == exp_ord[i], "R5",
                $sformatf("grant %0d got collector %0d exp %0d", i, order_log[i], exp_ord[i]));
        for (int i = 0; i < 4; i++)
            chk(last_lat[exp_ord[i]] == 2 + i, "R3",
                $sformatf("serialised latency got %0d exp %0d", last_lat[exp_ord[i]], 2 + i));
        watch = -1;

        // R4: writes to bank 4 hold off a read of bank 4 for three cycles
        set_req(0, 0, 4, 1);
        set_wr(0, 20, rnd_row());
        step();
        rd_req_valid = '0;
        for (int i = 0; i < 3; i++) begin
            set_wr(0, 20, rnd_row());
            step();
        end
        idle(6);
        chk(last_lat[0] == 5, "R4", $sformatf("blocked latency got %0d exp 5", last_lat[0]));

        // R6: queue fills while its bank is held by writes
        g0 = got[1];
        set_wr(3, 1, rnd_row());
        set_req(1, 0, 4, 0);
        step();
        set_wr(3, 1, rnd_row());
        set_req(1, 1, 3, 1);
        step();
        set_wr(3, 1, rnd_row());
        set_req(1, 2, 2, 2);
        chk(rd_req_ready[1] == 1'b0, "R6", $sformatf("ready when full got %b exp 0", rd_req_ready[1]));
        step();
        set_wr(3, 1, rnd_row());
        step();
        chk(got[1] == g0, "R4", $sformatf("responses while blocked got %0d exp %0d", got[1] - g0, 0));
        idle(8);
        chk(got[1] == g0 + 2, "R6", $sformatf("responses got %0d exp 2", got[1] - g0));
        chk(rd_req_ready[1] == 1'b1, "R6", $sformatf("ready after drain got %b exp 1", rd_req_ready[1]));

        // R8: a new value is visible to the next read
        val = rnd_row();
        set_wr(3, 11, val);
        step();
        wr_valid = 1'b0;
        set_req(3, 3, 11, 2);
        step();
        idle(4);
        chk(last_data[3] == val, "R8", $sformatf("data got %h exp %h", last_data[3], val));

        // random mix
        for (int i = 0; i < 3000; i++) begin
            for (int c = 0; c < NC; c++) begin
                if ($urandom_range(1, 0) == 1)
                    set_req(c, $urandom_range(NW-1, 0), $urandom_range(NR-1, 0), $urandom_range(NS-1, 0));
                else
                    rd_req_valid[c] = 1'b0;
            end
            if ($urandom_range(2, 0) == 0)
                set_wr($urandom_range(NW-1, 0), $urandom_range(NR-1, 0), rnd_row());
            else
                wr_valid = 1'b0;
            step();
        end
        idle(40);
        for (int c = 0; c < NC; c++)
            chk(tl[c] == hd[c], "R10",
                $sformatf("collector %0d outstanding got %0d exp 0", c, tl[c] - hd[c]));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule